// File: doc/BRIEF.md
# Program Counter with Two-Instruction Read Lookahead

This block keeps the program counter of a core that runs in two instruction states: a wide state with 4-byte instructions and a narrow state with 2-byte instructions. On each cycle in which an instruction retires, signalled by the step enable, the counter moves on by the size of the current instruction. If that instruction is a taken branch, the counter loads the branch target instead. The target is first aligned to the instruction size of the current state.

The block has two outputs. The fetch address is the address of the current instruction. The operand PC is the value an instruction receives when it names the PC as a source operand. That value is two instruction sizes ahead of the fetch address, which models a fetch stage running two instructions ahead of execute. The operand PC is a combinational function of the stored counter and the state select. It therefore follows a change of state within the same cycle.

Top module: `pc_lookahead`

## Requirements
- R1: While reset (`rst_ni` low) is applied, and after it is released until the first step, `fetch_addr_o` equals the parameter `RESET_VEC` (default 0).
- R2: With `narrow_i` = 0 (wide state), a step without a taken branch raises `fetch_addr_o` by 4 at the next rising clock edge.
- R3: With `narrow_i` = 1 (narrow state), a step without a taken branch raises `fetch_addr_o` by 2 at the next rising clock edge.
- R4: With `narrow_i` = 0, `opnd_pc_o` equals `fetch_addr_o` + 8 in the same cycle.
- R5: With `narrow_i` = 1, `opnd_pc_o` equals `fetch_addr_o` + 4 in the same cycle.
- R6: A step with `br_taken_i` = 1 in the wide state loads `br_target_i` with bits [1:0] cleared into the counter.
- R7: A step with `br_taken_i` = 1 in the narrow state loads `br_target_i` with bit [0] cleared into the counter.
- R8: With `step_i` low, the counter keeps its value, whatever `br_taken_i` and `br_target_i` carry.
- R9: Incrementing the counter and forming the operand PC both wrap modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | An instruction retires this cycle |
| narrow_i | input | 1 | 1 selects the 2-byte instruction state, 0 selects the 4-byte state |
| br_taken_i | input | 1 | The retiring instruction is a taken branch |
| br_target_i | input | ADDR_W | Branch destination address |
| fetch_addr_o | output | ADDR_W | Address of the current instruction |
| opnd_pc_o | output | ADDR_W | PC value returned to an instruction that reads the PC |

## Verification
The bench changes the state select without a step and checks that the operand PC moves from +8 to +4 at once. A design that registered the offset would show the old value for one cycle. Targets with the low bits set are used in both states. A design that applied the wide mask in the narrow state would lose bit 1, and a design with no mask would fetch from an odd address. A taken branch presented with step low must leave the counter unchanged; a design that let branches bypass the enable would jump. Branches to the top of the address space followed by a step check that the counter and the operand offset wrap to small addresses and are not held at the top.

// File: rtl/pc_lookahead.sv
module pc_lookahead #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              narrow_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] opnd_pc_o
);
  localparam logic [ADDR_W-1:0] WIDE_SZ   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] NARROW_SZ = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] WIDE_MSK  = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] NARROW_MSK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d, isz, tgt_al;

  assign isz    = narrow_i ? NARROW_SZ : WIDE_SZ;
  assign tgt_al = br_target_i & (narrow_i ? NARROW_MSK : WIDE_MSK);

  always_comb begin
    pc_d = pc_q;
    if (step_i) pc_d = br_taken_i ? tgt_al : pc_q + isz;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign opnd_pc_o    = pc_q + (isz << 1);
endmodule

// File: rtl/pc_lookahead_chk.sv
module pc_lookahead_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_i,
  input logic              narrow_i,
  input logic              br_taken_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [ADDR_W-1:0] opnd_pc_o
);
  a_r1_reset_vec: assert property (@(posedge clk_i)
    !rst_ni |=> fetch_addr_o == RESET_VEC);

  a_r2_wide_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !br_taken_i && !narrow_i |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(4));

  a_r3_narrow_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !br_taken_i && narrow_i |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(2));

  a_r4_wide_opnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !narrow_i |-> opnd_pc_o - fetch_addr_o == ADDR_W'(8));

  a_r5_narrow_opnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_i |-> opnd_pc_o - fetch_addr_o == ADDR_W'(4));

  a_r6_wide_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_taken_i && !narrow_i |=> fetch_addr_o == ($past(br_target_i) & ~ADDR_W'(3)));

  a_r7_narrow_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && br_taken_i && narrow_i |=> fetch_addr_o == ($past(br_target_i) & ~ADDR_W'(1)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(fetch_addr_o));
endmodule

bind pc_lookahead pc_lookahead_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .narrow_i(narrow_i),
  .br_taken_i(br_taken_i), .br_target_i(br_target_i),
  .fetch_addr_o(fetch_addr_o), .opnd_pc_o(opnd_pc_o)
);

// File: tb/pc_lookahead_tb.sv
module pc_lookahead_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, narrow = 1'b0, br = 1'b0;
  logic [31:0] tgt = '0;
  logic [31:0] fetch, opnd;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pc_lookahead #(.ADDR_W(32), .RESET_VEC(32'h0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .narrow_i(narrow),
    .br_taken_i(br), .br_target_i(tgt), .fetch_addr_o(fetch), .opnd_pc_o(opnd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic n, input logic b, input logic [31:0] t);
    @(negedge clk);
    step = s; narrow = n; br = b; tgt = t;
    @(negedge clk);
    step = 1'b0; br = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", fetch, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", fetch, 32'h0);
    chk("R4", opnd, 32'h8);
  endtask

  task automatic t_wide_steps;
    for (int i = 1; i <= 3; i++) begin
      cyc(1'b1, 1'b0, 1'b0, '0);
      chk("R2", fetch, 32'(4 * i));
      chk("R4", opnd, 32'(4 * i + 8));
    end
  endtask

  task automatic t_narrow_steps;
    @(negedge clk);
    narrow = 1'b1;
    #1;
    chk("R5", opnd, 32'd16);
    chk("R8", fetch, 32'd12);
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk("R3", fetch, 32'd14);
    chk("R5", opnd, 32'd18);
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk("R3", fetch, 32'd16);
  endtask

  task automatic t_branches;
    cyc(1'b1, 1'b0, 1'b1, 32'h0000_1003);
    chk("R6", fetch, 32'h0000_1000);
    cyc(1'b1, 1'b1, 1'b1, 32'h0000_2003);
    chk("R7", fetch, 32'h0000_2002);
    chk("R5", opnd, 32'h0000_2006);
  endtask

  task automatic t_hold;
    cyc(1'b0, 1'b0, 1'b1, 32'h0000_5000);
    chk("R8", fetch, 32'h0000_2002);
    cyc(1'b0, 1'b0, 1'b0, '0);
    chk("R8", fetch, 32'h0000_2002);
  endtask

  task automatic t_wrap;
    cyc(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFC);
    chk("R9", opnd, 32'h0000_0004);
    cyc(1'b1, 1'b0, 1'b0, '0);
    chk("R9", fetch, 32'h0000_0000);
    cyc(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk("R7", fetch, 32'hFFFF_FFFE);
    chk("R9", opnd, 32'h0000_0002);
    cyc(1'b1, 1'b1, 1'b0, '0);
    chk("R9", fetch, 32'h0000_0000);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", fetch, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_wide_steps();
    t_narrow_steps();
    t_branches();
    t_hold();
    t_wrap();
    cyc(1'b1, 1'b0, 1'b0, '0);
    t_reset_again();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule